// File: doc/BRIEF.md
# Host-to-Secure-Coprocessor Command Mailbox

This block is a memory-mapped mailbox. A host CPU uses it to hand commands to a secure coprocessor and to collect the results. The host first loads a bank of parameter words. It then writes a command word, and that write commits the command together with a snapshot of every parameter word into a small ordered queue. The coprocessor drains the queue from its own side. When it finishes a job it pushes a return value and a set of status words back into host-readable registers, and the same edge raises a completion cause.

Completion, a rejected command write, and the queue filling up are each recorded as a write-one-to-clear interrupt cause. A mask register gates these causes onto a single level interrupt line, and every cause is masked after reset. The host reads a queue status word to see the current fill count and whether the coprocessor reports itself ready.

Top module: `seccop_mailbox`

## Requirements
- R1: Parameter words 0 to 15 sit at byte offsets 0x00 to 0x3C, one word every 4 bytes. Each is read/write, resets to zero and reads back the last value written.
- R2: A write to offset 0x40 while fewer than 4 entries are queued enqueues one entry. The entry holds the written command word plus the current 16 parameter words, and the count rises by one.
- R3: The coprocessor sees entries in write order. `cop_cmd_valid` is high while the count is nonzero, `cop_params` carries parameter i in bits [32*i+31:32*i], and a `cop_pop` while valid removes the head entry and lowers the count by one. The count never exceeds 4.
- R4: The queue status word at offset 0xC4 carries `cop_online` in bit 8 and the queued count in bits 2:0. All other bits read zero.
- R5: A write to offset 0x40 while 4 entries are queued is dropped, and the count does not change. The next cycle shows cause bit 17 set and a one-cycle pulse on `cop_qfull_err`.
- R6: A `cop_done` cycle loads the return value (offset 0x80) and status words 0 to 15 (offsets 0x84 to 0xC0, status i in bits [32*i+31:32*i] of `cop_status`). The same clock edge sets cause bit 0.
- R7: Cause bit 18 is set on the clock edge at which the queued count becomes 4.
- R8: The cause register at offset 0xC8 clears each bit written with a 1. A set in the same cycle wins over a clear. Only bits 0, 17 and 18 can ever read as one.
- R9: The mask register at offset 0xCC is read/write and resets to all ones. `irq` is high exactly when some cause bit is set whose mask bit is 0.
- R10: Reads of undefined offsets (0x44 to 0x7C and 0xD0 upward) return zero. Writes to the read-only words at 0x80 to 0xC4 have no effect.
- R11: `hst_rdata` presents the addressed word in the cycle after `hst_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_addr | input | 8 | Host byte address |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rd | input | 1 | Host read strobe |
| hst_rdata | output | 32 | Host read data, registered |
| irq | output | 1 | Level interrupt to the host |
| cop_online | input | 1 | Coprocessor ready flag |
| cop_cmd_valid | output | 1 | Queue holds at least one entry |
| cop_cmd | output | 32 | Command word of the head entry |
| cop_params | output | 512 | Parameter words of the head entry |
| cop_pop | input | 1 | Remove the head entry |
| cop_done | input | 1 | Completion push strobe |
| cop_retval | input | 32 | Return value to load |
| cop_status | input | 512 | Status words to load |
| cop_qfull_err | output | 1 | Pulse after a dropped command write |

## Verification
The assertions check five things on every cycle. The count stays within its bound, and a pop without a push lowers it by exactly one. A command write into a full queue produces the error pulse and cause bit 17 while the count holds. Completion and filling the queue raise their causes. A fully masked state keeps `irq` low, and an unmasked completion drives it high. The bench scenarios cover what needs the data path end to end: the scoreboard compares each popped entry word by word with the snapshot the driver committed, and the bench reads back the completion payload, checks write-one-to-clear behaviour, confirms that read-only and undefined offsets hold or read zero, and reads the status word fields.

// File: rtl/seccop_mbox_pkg.sv
package seccop_mbox_pkg;
   // cause / mask bit positions
   localparam int CAUSE_DONE    = 0;
   localparam int CAUSE_OVERRUN = 17;
   localparam int CAUSE_FULL    = 18;
   localparam int CAUSE_TOP     = 18;
   // queue status word: ready flag position
   localparam int QSTAT_RDY     = 8;

   function automatic logic [CAUSE_TOP:0] cause_impl();
      logic [CAUSE_TOP:0] m;
      m = '0;
      m[CAUSE_DONE]    = 1'b1;
      m[CAUSE_OVERRUN] = 1'b1;
      m[CAUSE_FULL]    = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/seccop_cmd_queue.sv
module seccop_cmd_queue #(
   parameter int EW    = 544,
   parameter int DEPTH = 4,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [EW-1:0] push_data,
   input  logic          pop,
   output logic [EW-1:0] head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          fills
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("seccop_cmd_queue: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [EW-1:0] store [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = store[rd_ptr];
   assign fills   = do_push && !do_pop && (count == CW'(DEPTH - 1));

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/seccop_result_bank.sv
module seccop_result_bank #(
   parameter int DW     = 32,
   parameter int NPARAM = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DW-1:0]        retval_in,
   input  logic [NPARAM*DW-1:0] status_in,
   output logic [DW-1:0]        retval,
   output logic [NPARAM*DW-1:0] status
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    retval <= '0;
      else if (load) retval <= retval_in;
   end

   genvar g;
   generate
      for (g = 0; g < NPARAM; g++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    status[g*DW +: DW] <= '0;
            else if (load) status[g*DW +: DW] <= status_in[g*DW +: DW];
         end
      end
   endgenerate
endmodule

// File: rtl/seccop_irq_ctrl.sv
module seccop_irq_ctrl
   import seccop_mbox_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] set,
   input  logic [DW-1:0] clr,
   input  logic          mask_we,
   input  logic [DW-1:0] mask_wd,
   output logic [DW-1:0] cause,
   output logic [DW-1:0] mask,
   output logic          irq
);
   generate
      if (DW <= CAUSE_TOP) begin : g_bad_dw
         $error("seccop_irq_ctrl: DW too narrow for cause bits");
      end
   endgenerate

   localparam logic [DW-1:0] IMPL = DW'(cause_impl());

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause <= '0;
         mask  <= '1;
      end else begin
         cause <= ((cause & ~clr) | set) & IMPL;
         if (mask_we) mask <= mask_wd;
      end
   end

   assign irq = |(cause & ~mask);
endmodule

// File: rtl/seccop_mailbox.sv
module seccop_mailbox
   import seccop_mbox_pkg::*;
#(
   parameter int DW     = 32,
   parameter int NPARAM = 16,
   parameter int DEPTH  = 4,
   parameter int AW     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AW-1:0]        hst_addr,
   input  logic                 hst_wr,
   input  logic [DW-1:0]        hst_wdata,
   input  logic                 hst_rd,
   output logic [DW-1:0]        hst_rdata,
   output logic                 irq,
   input  logic                 cop_online,
   output logic                 cop_cmd_valid,
   output logic [DW-1:0]        cop_cmd,
   output logic [NPARAM*DW-1:0] cop_params,
   input  logic                 cop_pop,
   input  logic                 cop_done,
   input  logic [DW-1:0]        cop_retval,
   input  logic [NPARAM*DW-1:0] cop_status,
   output logic                 cop_qfull_err
);
   localparam int WAW = AW - 2;
   localparam int EW  = (NPARAM + 1) * DW;
   localparam int CW  = $clog2(DEPTH + 1);
   localparam logic [WAW-1:0] W_CMD = WAW'(NPARAM);
   localparam logic [WAW-1:0] W_RET = WAW'(2 * NPARAM);
   localparam logic [WAW-1:0] W_ST0 = WAW'(2 * NPARAM + 1);
   localparam logic [WAW-1:0] W_QS  = WAW'(3 * NPARAM + 1);
   localparam logic [WAW-1:0] W_CAU = WAW'(3 * NPARAM + 2);
   localparam logic [WAW-1:0] W_MSK = WAW'(3 * NPARAM + 3);

   generate
      if ((3 * NPARAM + 4) > (1 << WAW)) begin : g_bad_aw
         $error("seccop_mailbox: AW too small for register map");
      end
      if (CW > QSTAT_RDY || QSTAT_RDY >= DW) begin : g_bad_cw
         $error("seccop_mailbox: count field collides with ready flag");
      end
   endgenerate

   logic [WAW-1:0] widx;
   logic           unused_addr_lsb;
   assign widx            = hst_addr[AW-1:2];
   assign unused_addr_lsb = ^hst_addr[1:0];

   // ---------------- parameter staging and command word ----------------
   logic [NPARAM*DW-1:0] param_q;
   logic [DW-1:0]        last_cmd;
   logic                 cmd_wr, q_full, q_empty, q_fills, q_push, q_drop;
   logic [CW-1:0]        q_count;
   logic [EW-1:0]        q_head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         param_q  <= '0;
         last_cmd <= '0;
      end else if (hst_wr) begin
         for (int i = 0; i < NPARAM; i++)
            if (widx == WAW'(i)) param_q[i*DW +: DW] <= hst_wdata;
         if (widx == W_CMD) last_cmd <= hst_wdata;
      end
   end

   assign cmd_wr = hst_wr && (widx == W_CMD);
   assign q_push = cmd_wr && !q_full;
   assign q_drop = cmd_wr && q_full;

   seccop_cmd_queue #(.EW(EW), .DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data ({hst_wdata, param_q}),
      .pop       (cop_pop),
      .head      (q_head),
      .count     (q_count),
      .full      (q_full),
      .empty     (q_empty),
      .fills     (q_fills)
   );

   assign cop_cmd_valid = !q_empty;
   assign cop_cmd       = q_head[EW-1 -: DW];
   assign cop_params    = q_head[NPARAM*DW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cop_qfull_err <= 1'b0;
      else        cop_qfull_err <= q_drop;
   end

   // ---------------- completion payload ----------------
   logic [DW-1:0]        ret_q;
   logic [NPARAM*DW-1:0] stat_q;

   seccop_result_bank #(.DW(DW), .NPARAM(NPARAM)) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cop_done),
      .retval_in (cop_retval),
      .status_in (cop_status),
      .retval    (ret_q),
      .status    (stat_q)
   );

   // ---------------- interrupt causes ----------------
   logic [DW-1:0] cause_set, cause_clr, cause_q, mask_q;

   always_comb begin
      cause_set                = '0;
      cause_set[CAUSE_DONE]    = cop_done;
      cause_set[CAUSE_OVERRUN] = q_drop;
      cause_set[CAUSE_FULL]    = q_fills;
   end
   assign cause_clr = (hst_wr && widx == W_CAU) ? hst_wdata : '0;

   seccop_irq_ctrl #(.DW(DW)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (cause_set),
      .clr     (cause_clr),
      .mask_we (hst_wr && widx == W_MSK),
      .mask_wd (hst_wdata),
      .cause   (cause_q),
      .mask    (mask_q),
      .irq     (irq)
   );

   // ---------------- host read path ----------------
   logic [DW-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NPARAM; i++) begin
         if (widx == WAW'(i))          rd_mux = param_q[i*DW +: DW];
         if (widx == W_ST0 + WAW'(i))  rd_mux = stat_q[i*DW +: DW];
      end
      if (widx == W_CMD) rd_mux = last_cmd;
      if (widx == W_RET) rd_mux = ret_q;
      if (widx == W_QS) begin
         rd_mux[QSTAT_RDY] = cop_online;
         rd_mux[CW-1:0]    = q_count;
      end
      if (widx == W_CAU) rd_mux = cause_q;
      if (widx == W_MSK) rd_mux = mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hst_rdata <= '0;
      else if (hst_rd) hst_rdata <= rd_mux;
   end
endmodule

// File: rtl/seccop_mailbox_chk.sv
module seccop_mailbox_chk
   import seccop_mbox_pkg::*;
#(
   parameter int DW     = 32,
   parameter int NPARAM = 16,
   parameter int DEPTH  = 4,
   parameter int AW     = 8,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] hst_addr,
   input logic          hst_wr,
   input logic          irq,
   input logic          cop_done,
   input logic          cop_pop,
   input logic          cop_cmd_valid,
   input logic          cop_qfull_err,
   input logic [CW-1:0] q_count,
   input logic [DW-1:0] cause,
   input logic [DW-1:0] mask
);
   logic is_cmd_wr, is_mask_wr;
   assign is_cmd_wr  = hst_wr && (hst_addr[AW-1:2] == (AW-2)'(NPARAM));
   assign is_mask_wr = hst_wr && (hst_addr[AW-1:2] == (AW-2)'(3 * NPARAM + 3));

   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));

   a_r3_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
      (cop_pop && cop_cmd_valid && !is_cmd_wr) |=> (q_count == $past(q_count) - CW'(1)));

   a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmd_wr && q_count == CW'(DEPTH) && !cop_pop)
      |=> (cop_qfull_err && cause[CAUSE_OVERRUN] && q_count == CW'(DEPTH)));

   a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      cop_done |=> cause[CAUSE_DONE]);

   a_r7_full_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_count == CW'(DEPTH)) |-> cause[CAUSE_FULL]);

   a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask) |-> !irq);

   a_r9_done_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      (cop_done && !mask[CAUSE_DONE] && !is_mask_wr) |=> irq);
endmodule

bind seccop_mailbox seccop_mailbox_chk #(
   .DW(DW), .NPARAM(NPARAM), .DEPTH(DEPTH), .AW(AW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .hst_addr      (hst_addr),
   .hst_wr        (hst_wr),
   .irq           (irq),
   .cop_done      (cop_done),
   .cop_pop       (cop_pop),
   .cop_cmd_valid (cop_cmd_valid),
   .cop_qfull_err (cop_qfull_err),
   .q_count       (q_count),
   .cause         (cause_q),
   .mask          (mask_q)
);

// File: tb/sim_seccop_mailbox.sv
`timescale 1ns/1ps
module sim_seccop_mailbox;
   localparam int DW = 32, NP = 16, DEPTH = 4, AW = 8;
   localparam int EW = (NP + 1) * DW;

   logic             clk = 1'b0, rst_n = 1'b0;
   logic [AW-1:0]    hst_addr = '0;
   logic             hst_wr = 1'b0, hst_rd = 1'b0;
   logic [DW-1:0]    hst_wdata = '0, hst_rdata;
   logic             irq, cop_online = 1'b1, cop_cmd_valid, cop_pop = 1'b0;
   logic             cop_done = 1'b0, cop_qfull_err;
   logic [DW-1:0]    cop_cmd, cop_retval = '0;
   logic [NP*DW-1:0] cop_params, cop_status = '0;

   int errors = 0, checks = 0, err_pulses = 0;
   bit pop_en = 1'b0, finished = 1'b0;
   logic [EW-1:0] exp_q [$];

   always #4 clk = ~clk;

   seccop_mailbox #(.DW(DW), .NPARAM(NP), .DEPTH(DEPTH), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
      .hst_wdata(hst_wdata), .hst_rd(hst_rd), .hst_rdata(hst_rdata), .irq(irq),
      .cop_online(cop_online), .cop_cmd_valid(cop_cmd_valid), .cop_cmd(cop_cmd),
      .cop_params(cop_params), .cop_pop(cop_pop), .cop_done(cop_done),
      .cop_retval(cop_retval), .cop_status(cop_status), .cop_qfull_err(cop_qfull_err)
   );

   task automatic check(string tag, logic [EW-1:0] got, logic [EW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic hwr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
      @(negedge clk);
      hst_wr = 1'b0;
   endtask

   task automatic hrd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      hst_addr = a; hst_rd = 1'b1;
      @(negedge clk);
      hst_rd = 1'b0;
      d = hst_rdata;
   endtask

   // driver: load parameters, submit command, record expected entry
   task automatic send_cmd(logic [31:0] cmd, logic [31:0] base);
      logic [NP*DW-1:0] p;
      for (int i = 0; i < NP; i++) begin
         p[i*DW +: DW] = base + 32'(i * 17);
         hwr(8'(i * 4), base + 32'(i * 17));
      end
      if (exp_q.size() < DEPTH) exp_q.push_back({cmd, p});
      hwr(8'h40, cmd);
   endtask

   // monitor: pop entries and compare with scoreboard (R2, R3)
   initial begin
      forever begin
         @(negedge clk);
         cop_pop = 1'b0;
         if (pop_en && cop_cmd_valid) begin
            if (exp_q.size() == 0) check("R3 unexpected entry", {cop_cmd, cop_params}, '0);
            else check("R2 R3 popped entry", {cop_cmd, cop_params}, exp_q.pop_front());
            cop_pop = 1'b1;
         end
      end
   end

   always @(posedge clk) if (cop_qfull_err) err_pulses++;

   initial begin
      #(200000 * 8);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, keep;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      hrd(8'hCC, d); check("R9 mask reset", d, 32'hFFFF_FFFF);
      hrd(8'hC4, d); check("R4 status reset", d, 32'h100);
      hrd(8'hC8, d); check("R8 cause reset", d, 0);
      check("R9 irq reset", irq, 0);
      // fill the queue with no pops
      for (int k = 0; k < DEPTH; k++) send_cmd(32'hC000 + k, 32'h1000 * (k + 1));
      hrd(8'hC4, d); check("R4 count full", d, 32'h104);
      hrd(8'hC8, d); check("R7 full cause", d, 32'h0004_0000);
      hrd(8'h3C, d); check("R1 param readback", d, 32'h4000 + 15 * 17);
      // overflow
      send_cmd(32'hDEAD, 32'h9000);
      hrd(8'hC4, d); check("R5 count unchanged", d, 32'h104);
      hrd(8'hC8, d); check("R5 overrun cause", d, 32'h0006_0000);
      check("R5 error pulse count", err_pulses, 1);
      check("R9 masked irq low", irq, 0);
      hwr(8'hCC, 32'h0);
      @(negedge clk); check("R9 unmasked irq", irq, 1);
      hwr(8'hC8, 32'h0002_0000);
      hrd(8'hC8, d); check("R8 partial clear", d, 32'h0004_0000);
      hwr(8'hC8, 32'hFFFF_FFFF);
      hrd(8'hC8, d); check("R8 full clear", d, 0);
      check("R9 irq after clear", irq, 0);
      // drain
      pop_en = 1'b1;
      for (int t = 0; t < 50 && exp_q.size() != 0; t++) @(negedge clk);
      @(negedge clk);
      check("R3 scoreboard drained", exp_q.size(), 0);
      hrd(8'hC4, d); check("R4 count empty", d, 32'h100);
      // concurrent push and pop
      send_cmd(32'h5A5A, 32'h7700);
      send_cmd(32'hA5A5, 32'h8800);
      for (int t = 0; t < 50 && exp_q.size() != 0; t++) @(negedge clk);
      @(negedge clk);
      check("R3 second pattern drained", exp_q.size(), 0);
      // completion
      hwr(8'hCC, 32'hFFFF_FFFE);
      @(negedge clk);
      cop_retval = 32'hC0DE_0042;
      for (int i = 0; i < NP; i++) cop_status[i*DW +: DW] = 32'hA500_0000 | 32'(i * 3);
      cop_done = 1'b1;
      @(negedge clk);
      cop_done = 1'b0;
      check("R6 irq on done", irq, 1);
      hrd(8'hC8, d); check("R6 done cause", d, 32'h1);
      hrd(8'h80, d); check("R6 retval", d, 32'hC0DE_0042);
      hrd(8'h84, d); check("R6 status0", d, 32'hA500_0000);
      hrd(8'hC0, d); check("R6 status15", d, 32'hA500_002D);
      // read-only and undefined offsets
      hwr(8'h80, 32'h0);
      hwr(8'hC4, 32'hFFFF_FFFF);
      hrd(8'h80, d); check("R10 ro write ignored", d, 32'hC0DE_0042);
      hrd(8'hC4, d); check("R10 status write ignored", d, 32'h100);
      hrd(8'h44, d); check("R10 undefined 0x44", d, 0);
      hrd(8'hD0, d); check("R10 undefined 0xD0", d, 0);
      cop_online = 1'b0;
      hrd(8'hC4, d); check("R4 not ready", d, 0);
      // read data holds
      hrd(8'h84, keep);
      repeat (3) @(negedge clk);
      check("R11 rdata holds", hst_rdata, keep);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule